// File: doc/BRIEF.md
# Conversion Mode and Data-Ready Controller

This block decides when the converter core runs and holds the small amount of state that a serial bus slave reads and writes for it. It owns an 8-bit configuration byte, made up of a start/ready flag, two reserved bits, a single-shot select, a 2-bit rate code and a 2-bit gain code. It also owns the result register that the converter's filter loads through a one-cycle done pulse.

In continuous mode the block keeps the converter busy: every accepted result is stored and a new conversion starts on the following cycle. In single-shot mode the converter stays idle and the block reports power-down until a configuration write sets the top bit. That write launches exactly one conversion, after which the block returns to idle.

The top bit is not an ordinary status bit. Writing it requests a start. Reading it tells whether the result word fetched just before the configuration byte was fresh. The bus slave pulses a read strobe after it has returned the configuration byte, and that pulse marks the data as already seen. A general-call reset from the bus slave returns everything to the power-up state in a single cycle.

Top module: `cnv_seq_ctrl`

## Requirements
- R1: After reset the configuration byte reads 8Ch (flag 1, reserved 00, continuous mode, rate code 11, gain code 00), the result reads zero, no conversion is active, `cnv_start` is low and `pwr_down` is low.
- R2: A configuration write stores bits 6..0 of the byte. These read back in the same positions, with rate on bits 3..2 driving `rate_sel`, gain on bits 1..0 driving `gain_sel`, and bit 4 set to 1 selecting single-shot.
- R3: In continuous mode, a done pulse during an active conversion stores `cnv_result` in the result register, the conversion stays active, and `cnv_start` pulses in the next cycle. When the block is idle in continuous mode, a conversion starts on the next clock.
- R4: In continuous mode the value written to bit 7 has no effect: it launches nothing and does not change the read value of bit 7.
- R5: In single-shot mode while idle, writing a byte with bit 7 = 1 starts one conversion (`cnv_start` and `cnv_active` high in the next cycle). Writing bit 7 = 0 leaves the block idle.
- R6: In single-shot mode a done pulse stores the result, ends the conversion and asserts `pwr_down`. No further conversion starts without a new request.
- R7: Writing bit 7 = 1 in single-shot mode while a conversion is running produces no extra start and does not end the running conversion.
- R8: Bit 7 reads 0 in the cycle after a result is stored and reads 1 after a configuration-read strobe. When both happen in the same cycle, the stored result wins and the bit reads 0.
- R9: Switching from continuous to single-shot mid-conversion lets that conversion finish and store its result, after which the block is idle and powered down.
- R10: A general-call reset pulse aborts any conversion, clears the result to zero and restores the configuration byte to 8Ch. The pulse takes priority over every other input in that cycle.
- R11: In continuous mode, a write that changes the rate or gain code while a conversion runs restarts it (`cnv_start` pulses and the block stays active). A write that leaves both codes unchanged does not restart it.
- R12: `pwr_down` is high exactly when single-shot mode is selected and no conversion is active.
- R13: A done pulse while no conversion is active is ignored: the result register and the bit 7 read value do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| cfg_wr_en | input | 1 | One-cycle strobe: the bus slave writes a configuration byte |
| cfg_wr_data | input | 8 | Configuration byte being written |
| cfg_rd_en | input | 1 | One-cycle strobe: the configuration byte has just been returned on the bus |
| gcall_rst | input | 1 | One-cycle general-call reset request |
| cnv_done | input | 1 | One-cycle pulse from the filter: a conversion result is valid |
| cnv_result | input | RES_W | Conversion result that accompanies `cnv_done` |
| cfg_rd_data | output | 8 | Configuration byte as seen by a bus read, bit 7 being the ready flag |
| result_q | output | RES_W | Result register |
| rate_sel | output | 2 | Current rate code for the filter |
| gain_sel | output | 2 | Current gain code for the input amplifier |
| cnv_start | output | 1 | Pulse in the first cycle of each new or restarted conversion |
| cnv_active | output | 1 | A conversion is in progress |
| pwr_down | output | 1 | Converter may be powered down |

## Verification
The bench builds the block with an 8-bit result width. At that width, feeding every possible result code through the continuous-mode done path is a short run, so all 256 codes are stored and read back, interleaved with read strobes and with read-and-done collisions. Because the configuration byte is only eight bits at any result width, the bench also writes each of its 256 values from a freshly reset state and predicts the read-back, the rate and gain outputs, and whether a conversion launches or the block powers down. Directed sequences then cover the cases that involve ordering: a restart on a field change, a mode switch mid-conversion, a start request while busy, a done pulse while idle, and a general-call reset that aborts a running conversion.

// File: rtl/cnv_seq_pkg.sv
package cnv_seq_pkg;

  localparam int unsigned CFG_W        = 8;
  localparam int unsigned FLAG_BIT     = 7;
  localparam logic [CFG_W-1:0] CFG_RESET_BYTE = 8'h8C;
  localparam logic        FLAG_RESET   = CFG_RESET_BYTE[FLAG_BIT];

  // Stored configuration bits in their bus positions 6..0.
  typedef struct packed {
    logic [1:0] rsv;
    logic       single;
    logic [1:0] rate;
    logic [1:0] gain;
  } cnv_cfg_t;

  localparam cnv_cfg_t CFG_DEFAULT = cnv_cfg_t'(CFG_RESET_BYTE[FLAG_BIT-1:0]);

  typedef enum logic {
    CNV_IDLE = 1'b0,
    CNV_BUSY = 1'b1
  } cnv_state_e;

  function automatic logic [CFG_W-1:0] pack_cfg(input logic flag, input cnv_cfg_t c);
    return {flag, c};
  endfunction

endpackage

// File: rtl/cnv_cfg_reg.sv
module cnv_cfg_reg
  import cnv_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [CFG_W-2:0] wr_bits,
  output cnv_cfg_t         cfg_q,
  output cnv_cfg_t         cfg_nxt,
  output logic             tune_chg
);

  cnv_cfg_t wr_cfg;
  logic     cfg_en;

  assign wr_cfg = cnv_cfg_t'(wr_bits);
  assign cfg_en = clr | wr_en;

  always_comb begin
    cfg_nxt = cfg_q;
    if (clr) begin
      cfg_nxt = CFG_DEFAULT;
    end else if (wr_en) begin
      cfg_nxt = wr_cfg;
    end
  end

  always_comb begin
    tune_chg = wr_en && !clr &&
               ({wr_cfg.rate, wr_cfg.gain} != {cfg_q.rate, cfg_q.gain});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_DEFAULT;
    end else if (cfg_en) begin
      cfg_q <= cfg_nxt;
    end
  end

  assert_gcall_cfg_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cfg_q == CFG_DEFAULT));

  assert_write_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (cfg_q == $past(wr_cfg)));

endmodule

// File: rtl/cnv_fsm.sv
module cnv_fsm
  import cnv_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic done_in,
  input  logic single_nxt,
  input  logic start_req,
  input  logic tune_chg,
  output logic active_q,
  output logic start_q,
  output logic done_acc
);

  cnv_state_e state_q, state_d;
  logic       start_d;
  logic       restart;
  logic       launch;

  assign active_q = (state_q == CNV_BUSY);
  assign done_acc = done_in && active_q;
  assign restart  = active_q && tune_chg && !single_nxt;
  assign launch   = !single_nxt || start_req;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    if (clr) begin
      state_d = CNV_IDLE;
    end else begin
      unique case (state_q)
        CNV_BUSY: begin
          if (done_acc) begin
            state_d = single_nxt ? CNV_IDLE : CNV_BUSY;
            start_d = !single_nxt;
          end else if (restart) begin
            start_d = 1'b1;
          end
        end
        CNV_IDLE: begin
          if (launch) begin
            state_d = CNV_BUSY;
            start_d = 1'b1;
          end
        end
        default: state_d = CNV_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CNV_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && single_nxt && !done_in && !clr) |=> (active_q && !start_q));

  assert_single_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && single_nxt && !clr) |=> !active_q);

  assert_tune_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && tune_chg && !single_nxt && !clr) |=> (active_q && start_q));

  assert_cont_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && !single_nxt && !clr) |=> (active_q && start_q));

endmodule

// File: rtl/cnv_result_reg.sv
module cnv_result_reg
  import cnv_seq_pkg::*;
#(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [RES_W-1:0] res_in,
  input  logic             rd_seen,
  output logic [RES_W-1:0] result_q,
  output logic             flag_q
);

  logic [RES_W-1:0] result_d;
  logic             flag_d;
  logic             res_en;
  logic             flag_en;

  assign res_en  = clr | load;
  assign flag_en = clr | load | rd_seen;

  always_comb begin
    result_d = result_q;
    if (clr) begin
      result_d = '0;
    end else if (load) begin
      result_d = res_in;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (clr) begin
      flag_d = FLAG_RESET;
    end else if (load) begin
      flag_d = 1'b0;
    end else if (rd_seen) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (res_en) begin
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= FLAG_RESET;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assert_new_data_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (!flag_q && result_q == $past(res_in)));

  assert_read_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_seen && !load && !clr) |=> flag_q);

  assert_gcall_clears_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (result_q == '0 && flag_q));

endmodule

// File: rtl/cnv_seq_ctrl.sv
module cnv_seq_ctrl
  import cnv_seq_pkg::*;
#(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [7:0]       cfg_wr_data,
  input  logic             cfg_rd_en,
  input  logic             gcall_rst,
  input  logic             cnv_done,
  input  logic [RES_W-1:0] cnv_result,
  output logic [7:0]       cfg_rd_data,
  output logic [RES_W-1:0] result_q,
  output logic [1:0]       rate_sel,
  output logic [1:0]       gain_sel,
  output logic             cnv_start,
  output logic             cnv_active,
  output logic             pwr_down
);

  cnv_cfg_t cfg_q;
  cnv_cfg_t cfg_nxt;
  logic     tune_chg;
  logic     start_req;
  logic     done_acc;
  logic     flag_q;

  assign start_req = cfg_wr_en && cfg_wr_data[FLAG_BIT];

  cnv_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (gcall_rst),
    .wr_en    (cfg_wr_en),
    .wr_bits  (cfg_wr_data[FLAG_BIT-1:0]),
    .cfg_q    (cfg_q),
    .cfg_nxt  (cfg_nxt),
    .tune_chg (tune_chg)
  );

  cnv_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (gcall_rst),
    .done_in    (cnv_done),
    .single_nxt (cfg_nxt.single),
    .start_req  (start_req),
    .tune_chg   (tune_chg),
    .active_q   (cnv_active),
    .start_q    (cnv_start),
    .done_acc   (done_acc)
  );

  cnv_result_reg #(
    .RES_W (RES_W)
  ) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (gcall_rst),
    .load     (done_acc),
    .res_in   (cnv_result),
    .rd_seen  (cfg_rd_en),
    .result_q (result_q),
    .flag_q   (flag_q)
  );

  assign cfg_rd_data = pack_cfg(flag_q, cfg_q);
  assign rate_sel    = cfg_q.rate;
  assign gain_sel    = cfg_q.gain;
  assign pwr_down    = cfg_q.single && !cnv_active;

  assert_idle_done_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_done && !cnv_active && !gcall_rst) |=> ($stable(result_q) && $stable(cfg_rd_data[FLAG_BIT])));

  assert_cont_write_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_rd_en && !cnv_done && !gcall_rst) |=> $stable(cfg_rd_data[FLAG_BIT]));

  assert_pwr_implies_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !cnv_start);

endmodule

// File: tb/tb_cnv_seq_ctrl.sv
module tb_cnv_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RW         = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [7:0]    cfg_wr_data;
  logic          cfg_rd_en;
  logic          gcall_rst;
  logic          cnv_done;
  logic [RW-1:0] cnv_result;
  logic [7:0]    cfg_rd_data;
  logic [RW-1:0] result_q;
  logic [1:0]    rate_sel;
  logic [1:0]    gain_sel;
  logic          cnv_start;
  logic          cnv_active;
  logic          pwr_down;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnv_seq_ctrl #(.RES_W(RW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_en   (cfg_rd_en),
    .gcall_rst   (gcall_rst),
    .cnv_done    (cnv_done),
    .cnv_result  (cnv_result),
    .cfg_rd_data (cfg_rd_data),
    .result_q    (result_q),
    .rate_sel    (rate_sel),
    .gain_sel    (gain_sel),
    .cnv_start   (cnv_start),
    .cnv_active  (cnv_active),
    .pwr_down    (pwr_down)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_in();
    cfg_wr_en   = 1'b0;
    cfg_wr_data = 8'h00;
    cfg_rd_en   = 1'b0;
    gcall_rst   = 1'b0;
    cnv_done    = 1'b0;
    cnv_result  = '0;
  endtask

  task automatic wr(input logic [7:0] b);
    cfg_wr_en = 1'b1; cfg_wr_data = b; tick(); idle_in();
  endtask

  task automatic done(input logic [RW-1:0] v);
    cnv_done = 1'b1; cnv_result = v; tick(); idle_in();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 cfg", cfg_rd_data, 8'h8C);
    chk("R1 result", result_q, 0);
    chk("R1 active", cnv_active, 0);
    chk("R1 start", cnv_start, 0);
    chk("R1 pwr_down", pwr_down, 0);
    tick();
    chk("R3 launch active", cnv_active, 1);
    chk("R3 launch start", cnv_start, 1);

    // R3/R8: every result code through the continuous path
    for (int v = 0; v < 256; v++) begin
      done(RW'(v));
      chk("R3 result", result_q, v);
      chk("R8 flag new", cfg_rd_data[7], 0);
      chk("R3 active", cnv_active, 1);
      chk("R3 start", cnv_start, 1);
      if (v % 2 == 1) begin
        cfg_rd_en = 1'b1; tick(); idle_in();
        chk("R8 flag seen", cfg_rd_data[7], 1);
        chk("R3 no start", cnv_start, 0);
      end else if (v % 4 == 2) begin
        cfg_rd_en = 1'b1; cnv_done = 1'b1; cnv_result = RW'(v ^ 8'hA5); tick(); idle_in();
        chk("R8 collision flag", cfg_rd_data[7], 0);
        chk("R8 collision result", result_q, v ^ 8'hA5);
      end
    end
    cfg_rd_en = 1'b1; tick(); idle_in();
    chk("R8 flag seen", cfg_rd_data[7], 1);

    // R11 / R4
    wr(8'h88);
    chk("R11 restart start", cnv_start, 1);
    chk("R11 restart active", cnv_active, 1);
    chk("R2 rate", rate_sel, 2'b10);
    chk("R2 cfg", cfg_rd_data, 8'h88);
    wr(8'h08);
    chk("R11 same fields no restart", cnv_start, 0);
    chk("R4 flag unchanged", cfg_rd_data, 8'h88);
    wr(8'h8B);
    chk("R11 gain change restart", cnv_start, 1);
    chk("R2 gain", gain_sel, 2'b11);

    // R9: continuous to single-shot mid-conversion
    wr(8'h1B);
    chk("R9 still active", cnv_active, 1);
    chk("R9 no start", cnv_start, 0);
    chk("R12 pwr low busy", pwr_down, 0);
    done(8'h3C);
    chk("R9 idle", cnv_active, 0);
    chk("R9 pwr_down", pwr_down, 1);
    chk("R9 result", result_q, 8'h3C);
    chk("R9 no start", cnv_start, 0);

    // R13: done while idle
    done(8'h77);
    chk("R13 result kept", result_q, 8'h3C);
    chk("R13 flag kept", cfg_rd_data[7], 0);
    chk("R13 idle", cnv_active, 0);

    // R5
    wr(8'h1B);
    chk("R5 bit7 zero idle", cnv_active, 0);
    chk("R5 pwr_down", pwr_down, 1);
    wr(8'h9B);
    chk("R5 start", cnv_start, 1);
    chk("R5 active", cnv_active, 1);
    chk("R12 pwr low", pwr_down, 0);
    chk("R8 flag read independent of write", cfg_rd_data, 8'h1B);

    // R7 / R6
    wr(8'h9B);
    chk("R7 no extra start", cnv_start, 0);
    chk("R7 still active", cnv_active, 1);
    done(8'h81);
    chk("R6 idle", cnv_active, 0);
    chk("R6 pwr_down", pwr_down, 1);
    chk("R6 result", result_q, 8'h81);
    tick(); tick();
    chk("R6 stays idle", cnv_active, 0);
    chk("R6 no start", cnv_start, 0);

    // R10: general-call reset aborting a conversion
    wr(8'h0C);
    chk("R3 idle launch", cnv_start, 1);
    done(8'h42);
    chk("R3 result", result_q, 8'h42);
    gcall_rst = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = 8'h9F; tick(); idle_in();
    chk("R10 cfg", cfg_rd_data, 8'h8C);
    chk("R10 result", result_q, 0);
    chk("R10 aborted", cnv_active, 0);
    chk("R10 no start", cnv_start, 0);
    tick();
    chk("R10 relaunch", cnv_active, 1);

    // R2/R5/R12: every configuration byte from a fresh reset
    for (int d = 0; d < 256; d++) begin
      logic [7:0] b;
      b = 8'(d);
      gcall_rst = 1'b1; tick(); idle_in();
      wr(b);
      chk("R2 readback", cfg_rd_data, {1'b1, b[6:0]});
      chk("R2 rate_sel", rate_sel, b[3:2]);
      chk("R2 gain_sel", gain_sel, b[1:0]);
      chk("R5 launch", cnv_active, (!b[4] || b[7]) ? 1 : 0);
      chk("R12 pwr_down", pwr_down, (b[4] && !b[7]) ? 1 : 0);
    end

    summary();
    $finish;
  end

endmodule